// File: doc/BRIEF.md
# GPIO Port Atomic Register Bank

This block is the register side of one 32-bit general-purpose I/O port. Software reaches it over a simple single-cycle bus made of a byte address, a write strobe, write data and read data. It owns two writable registers: the output level register and the direction register. Each of them can be changed with a plain write, or bit by bit through separate set, clear and invert aliases. Firmware can therefore change a few pins without a read-modify-write sequence that could race against another agent.

The pad side carries three vectors: the raw pin levels coming in, the output levels going out and the per-pin output enables. Output levels reach the pad only on pins configured as outputs. Incoming levels pass through a two-flop synchronizer before software can read them. Read data is registered, so it always returns one clock after the address is presented.

Top module: `gpio_alias_bank`

## Requirements
- R1: After a synchronous reset, the output register and the direction register are zero. pad_oe, pad_out and bus_rdata are all zero.
- R2: A write to the plain alias replaces the whole register. The output register's plain alias is at byte address 0x100 and the direction register's is at 0x200.
- R3: A write to the set alias (base + 0x4) ORs the written ones into the register. Bits written as 0 keep their value.
- R4: A write to the clear alias (base + 0x8) forces the written ones to 0. Bits written as 0 keep their value.
- R5: A write to the invert alias (base + 0xC) flips the written ones. Bits written as 0 keep their value.
- R6: pad_oe[i] equals direction bit i, where 1 means output and 0 means input. pad_out[i] equals output bit i when direction bit i is 1, and 0 otherwise.
- R7: Reading address 0x000 returns the pin levels, with 1 for a high pin. The levels pass through a two-flop synchronizer, so with the address held, bus_rdata shows a pin change on the third rising edge after the change and not earlier.
- R8: The input register is read-only. A write to 0x000 changes neither its read value nor the output or direction registers.
- R9: Reads of the set, clear and invert aliases return the current value of their register.
- R10: Any other address reads 0, and a write to it changes nothing. This covers 0x004 to 0x00C, addresses whose two low bits are not zero, and every slot outside 0x000, 0x100 and 0x200.
- R11: bus_rdata is registered: it shows the register addressed before a rising edge, as that register stood before that edge. A read in a cycle that also writes returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data, or bit mask for the alias operations |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pad_in | input | 32 | Raw pin levels, asynchronous to clk |
| pad_out | output | 32 | Output levels, already masked by direction |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
The collision that matters is a register update and a read of that same register in one cycle. An access to an alias address with bus_we high both modifies the register and loads the read data. The bench drives an invert write to 0x10C and samples bus_rdata on the next cycle. That sample must still hold the value from before the write, and a plain read after it must show the inverted bits. The other interaction is a direction change altering pad_out in the cycle it lands. This is judged by comparing pad_out against the expected output value ANDed with the expected direction after every alias sequence.

// File: rtl/gpio_ab_pkg.sv
package gpio_ab_pkg;

  // Alias operation, taken from byte address bits [3:2] inside a 16-byte slot
  typedef enum logic [1:0] {
    OP_VAL = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TGL = 2'd3
  } alias_op_t;

  typedef struct packed {
    logic      sel_in;
    logic      sel_dout;
    logic      sel_dir;
    alias_op_t op;
  } dec_t;

endpackage

// File: rtl/gpio_ab_decode.sv
module gpio_ab_decode
  import gpio_ab_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int IN_BASE   = 'h000,
  parameter int DOUT_BASE = 'h100,
  parameter int DIR_BASE  = 'h200
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W-1:0] IN_SLOT   = SLOT_W'(IN_BASE   >> 4);
  localparam logic [SLOT_W-1:0] DOUT_SLOT = SLOT_W'(DOUT_BASE >> 4);
  localparam logic [SLOT_W-1:0] DIR_SLOT  = SLOT_W'(DIR_BASE  >> 4);

  logic [SLOT_W-1:0] slot;
  logic              aligned;
  alias_op_t         op;

  assign slot    = addr[ADDR_W-1:4];
  assign aligned = (addr[1:0] == 2'b00);
  assign op      = alias_op_t'(addr[3:2]);

  always_comb begin
    dec          = '0;
    dec.op       = op;
    dec.sel_in   = aligned && (slot == IN_SLOT) && (op == OP_VAL);
    dec.sel_dout = aligned && (slot == DOUT_SLOT);
    dec.sel_dir  = aligned && (slot == DIR_SLOT);
  end

  // at most one target selected per access
  always_comb begin
    if (!$isunknown(addr))
      assert ($onehot0({dec.sel_in, dec.sel_dout, dec.sel_dir}))
        else $error("p_onehot_sel_r10: more than one target selected");
  end

endmodule

// File: rtl/gpio_ab_alias_reg.sv
module gpio_ab_alias_reg
  import gpio_ab_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  alias_op_t    op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      case (op)
        OP_VAL:  q <= wdata;
        OP_SET:  q <= q | wdata;
        OP_CLR:  q <= q & ~wdata;
        default: q <= q ^ wdata;
      endcase
    end
  end

  p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_SET) |=>
      ((q & $past(wdata)) == $past(wdata)) &&
      ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))
    else $error("p_set_or_r3");

  p_clr_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_CLR) |=>
      ((q & $past(wdata)) == '0) &&
      ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))
    else $error("p_clr_mask_r4");

  p_tgl_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_TGL) |=> ((q ^ $past(q)) == $past(wdata)))
    else $error("p_tgl_flip_r5");

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q))
    else $error("p_hold_idle_r10");

endmodule

// File: rtl/gpio_ab_sync.sv
module gpio_ab_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

  p_sync_step_r7: assert property (@(posedge clk) disable iff (rst)
    q == $past(chain[STAGES-2]))
    else $error("p_sync_step_r7");

endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_ab_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int IN_BASE     = 'h000,
  parameter int DOUT_BASE   = 'h100,
  parameter int DIR_BASE    = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe
);

  dec_t              dec;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] in_sync;
  logic [DATA_W-1:0] rd_next;

  gpio_ab_decode #(
    .ADDR_W   (ADDR_W),
    .IN_BASE  (IN_BASE),
    .DOUT_BASE(DOUT_BASE),
    .DIR_BASE (DIR_BASE)
  ) u_dec (
    .addr(bus_addr),
    .dec (dec)
  );

  gpio_ab_alias_reg #(.W(DATA_W)) u_dout (
    .clk  (clk),
    .rst  (rst),
    .wr_en(bus_we && dec.sel_dout),
    .op   (dec.op),
    .wdata(bus_wdata),
    .q    (dout_q)
  );

  gpio_ab_alias_reg #(.W(DATA_W)) u_dir (
    .clk  (clk),
    .rst  (rst),
    .wr_en(bus_we && dec.sel_dir),
    .op   (dec.op),
    .wdata(bus_wdata),
    .q    (dir_q)
  );

  gpio_ab_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pad_in),
    .q  (in_sync)
  );

  // read mux: every alias of a group returns the register itself
  always_comb begin
    rd_next = '0;
    if (dec.sel_in)   rd_next = in_sync;
    if (dec.sel_dout) rd_next = dout_q;
    if (dec.sel_dir)  rd_next = dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign pad_oe  = dir_q;
  assign pad_out = dout_q & dir_q;

  p_pad_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0)
    else $error("p_pad_masked_r6");

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !(dec.sel_in || dec.sel_dout || dec.sel_dir) |=> bus_rdata == '0)
    else $error("p_unmapped_zero_r10");

  p_read_old_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_we && dec.sel_dout) |=> bus_rdata == $past(dout_q))
    else $error("p_read_old_r11");

endmodule

// File: tb/gpio_alias_bank_bench.sv
`timescale 1ns/1ps
module gpio_alias_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_alias_bank u_gpio_alias_bank (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 10;
  localparam logic [87:0] VECS [NV] = '{
    {12'h100, 32'hA5A5_0F0F, 12'h100, 32'hA5A5_0F0F}, // R2
    {12'h104, 32'h0000_F0F0, 12'h100, 32'hA5A5_FFFF}, // R3
    {12'h108, 32'hA000_000F, 12'h100, 32'h05A5_FFF0}, // R4
    {12'h10C, 32'hFFFF_0000, 12'h100, 32'hFA5A_FFF0}, // R5
    {12'h200, 32'h1234_5678, 12'h200, 32'h1234_5678}, // R2
    {12'h204, 32'h0000_0007, 12'h200, 32'h1234_567F}, // R3
    {12'h208, 32'h1200_0000, 12'h200, 32'h0034_567F}, // R4
    {12'h20C, 32'h0000_00FF, 12'h200, 32'h0034_5680}, // R5
    {12'h10C, 32'h0000_0000, 12'h104, 32'hFA5A_FFF0}, // R9
    {12'h304, 32'hFFFF_FFFF, 12'h208, 32'h0034_5680}  // R9 and R10
  };
  localparam int VTAG [NV] = '{2, 3, 4, 5, 2, 3, 4, 5, 9, 10};

  localparam logic [31:0] DOUT_EXP = 32'hFA5A_FFF0;
  localparam logic [31:0] DIR_EXP  = 32'h0034_5680;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(12'h100, rd); check("R1 dout", rd, 32'h0);
    bus_read(12'h200, rd); check("R1 dir", rd, 32'h0);

    // vector table: alias writes and read-back
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i][87:76], VECS[i][75:44]);
      bus_read(VECS[i][43:32], rd);
      checks++;
      if (rd !== VECS[i][31:0]) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%08h expected=%08h",
                 VTAG[i], i, rd, VECS[i][31:0]);
      end
    end

    // R6 pad masking by direction
    check("R6 pad_oe", pad_oe, DIR_EXP);
    check("R6 pad_out", pad_out, DOUT_EXP & DIR_EXP);

    // R7 synchronizer latency with address held at the input register
    @(negedge clk);
    bus_addr = 12'h000; bus_we = 1'b0;
    pad_in = 32'hC3C3_5A5A;
    @(negedge clk); check("R7 after 1 edge", bus_rdata, 32'h0);
    @(negedge clk); check("R7 after 2 edges", bus_rdata, 32'h0);
    @(negedge clk); check("R7 after 3 edges", bus_rdata, 32'hC3C3_5A5A);

    // R8 input register is read-only
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_read(12'h000, rd); check("R8 input", rd, 32'hC3C3_5A5A);
    bus_read(12'h100, rd); check("R8 dout", rd, DOUT_EXP);
    bus_read(12'h200, rd); check("R8 dir", rd, DIR_EXP);

    // R9 alias reads
    bus_read(12'h108, rd); check("R9 clear alias read", rd, DOUT_EXP);
    bus_read(12'h20C, rd); check("R9 invert alias read", rd, DIR_EXP);

    // R10 unmapped addresses
    bus_read(12'h004, rd); check("R10 0x004", rd, 32'h0);
    bus_read(12'h00C, rd); check("R10 0x00C", rd, 32'h0);
    bus_read(12'h101, rd); check("R10 misaligned", rd, 32'h0);
    bus_read(12'hFFC, rd); check("R10 0xFFC", rd, 32'h0);
    bus_write(12'h102, 32'hFFFF_FFFF);
    bus_write(12'h20E, 32'hFFFF_FFFF);
    bus_read(12'h100, rd); check("R10 dout after stray", rd, DOUT_EXP);
    bus_read(12'h200, rd); check("R10 dir after stray", rd, DIR_EXP);

    // R11 write and read of the same register in one cycle
    @(negedge clk);
    bus_addr = 12'h10C; bus_wdata = 32'h0000_00FF; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R11 same-cycle read", bus_rdata, DOUT_EXP);
    bus_read(12'h100, rd); check("R11 after write", rd, DOUT_EXP ^ 32'h0000_00FF);
    check("R6 pad_out after invert", pad_out, (DOUT_EXP ^ 32'h0000_00FF) & DIR_EXP);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule